// File: doc/BRIEF.md
# Extended Integer Divide Unit

This block carries out three extended divide operations over several clock cycles on behalf of an instruction pipeline. A caller presents three 16-bit operands (named after the architectural registers Y, D and X), picks an operation with a two-bit mode code and pulses `start`. The unit computes the quotient and remainder with a restoring shift-subtract loop that retires one quotient bit per clock. It then raises `done` for one cycle with the results, the condition flags and one write strobe for each destination register.

The wide modes divide the 32-bit value formed from Y (upper half) and D (lower half) by X. The unsigned variant treats every operand as unsigned. The signed variant treats the dividend and divisor as two's complement. In both wide modes the quotient is written to Y and the remainder to D. The narrow mode divides the signed 16-bit D by the signed X, writes the quotient to X and the remainder to D. Signed results truncate toward zero. A zero divisor is flagged through C and leaves every result register untouched. A quotient that does not fit in the destination is flagged through V.

Top module: `xdiv_unit`

## Requirements
- R1: After reset, `busy`, `done`, all write strobes, all result outputs and all four flags are 0.
- R2: Mode 0 (unsigned wide) divides the unsigned value {Y,D} by unsigned X. The low 16 quotient bits go to `res_y`, the remainder goes to `res_d`, and `wr_y` and `wr_d` pulse with `done` while `wr_x` stays low.
- R3: In mode 0, V is 1 exactly when the quotient is 65536 or more. The results are still written, truncated to the low 16 quotient bits.
- R4: With a nonzero divisor, C is 0. Z is 1 exactly when the full untruncated quotient is zero. N equals bit 15 of the written quotient.
- R5: Mode 1 (signed wide) divides the signed 32-bit {Y,D} by signed X. The quotient rounds toward zero, the remainder takes the sign of the dividend, and the destinations and strobes are the same as in mode 0.
- R6: In mode 1, V is 1 exactly when the true quotient lies outside -32768 to 32767.
- R7: Mode 2 (signed narrow) divides signed D by signed X. It writes the quotient to `res_x` and the remainder to `res_d` (strobes `wr_x`, `wr_d`), leaves Y unwritten, and sets V only when the quotient is outside the signed 16-bit range.
- R8: A zero X sets C to 1 and Z, N, V to 0. No write strobe rises, and `res_y`, `res_x` and `res_d` keep their previous values.
- R9: `done` is a one-cycle pulse. Counting clock edges after the edge that accepts `start`, it is visible after edge 33 for the wide modes, after edge 17 for mode 2, and after edge 1 for a zero divisor. `busy` is high from the cycle after the start until `done`.
- R10: A `start` pulse while `busy` is high is ignored. The running operation completes with its own operands and latency.
- R11: Mode code 3 behaves as mode 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (accepted when not busy) |
| mode | input | 2 | 0 unsigned wide, 1 signed wide, 2 signed narrow, 3 as 0 |
| in_y | input | 16 | Upper dividend half (wide modes) |
| in_d | input | 16 | Lower dividend half, or narrow dividend |
| in_x | input | 16 | Divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| wr_y | output | 1 | Write strobe for Y destination |
| wr_x | output | 1 | Write strobe for X destination |
| wr_d | output | 1 | Write strobe for D destination |
| res_y | output | 16 | Quotient for the wide modes |
| res_x | output | 16 | Quotient for the narrow mode |
| res_d | output | 16 | Remainder |
| flag_z | output | 1 | Quotient is zero |
| flag_n | output | 1 | Bit 15 of the written quotient |
| flag_v | output | 1 | Quotient overflow |
| flag_c | output | 1 | Divisor was zero |

## Verification
On every cycle the assertions check the handshake and strobe rules: `done` lasts one cycle and never coincides with `busy`, an accepted start leads to `busy` or an immediate `done`, a zero-divisor completion raises no strobe, and a normal completion writes D plus exactly one quotient destination. They also check that a set Z flag comes with a zero written quotient and a clear N. The arithmetic can only be shown by the bench's scenarios. These cover the quotient and remainder values, rounding toward zero and the sign of the remainder, the exact overflow boundaries of each mode, the retained results after a zero divisor, the per-mode latency, and a start ignored in mid-operation.

// File: rtl/xdiv_pkg.sv
package xdiv_pkg;

    typedef enum logic [1:0] {
        XD_UWIDE   = 2'd0,
        XD_SWIDE   = 2'd1,
        XD_SNARROW = 2'd2,
        XD_RSVD    = 2'd3
    } xd_mode_e;

    typedef enum logic [1:0] {
        XS_IDLE = 2'd0,
        XS_RUN  = 2'd1,
        XS_FIN  = 2'd2
    } xd_state_e;

endpackage

// File: rtl/xdiv_operand_prep.sv
// Turns the raw operands into magnitudes and records the result signs.
module xdiv_operand_prep
    import xdiv_pkg::*;
#(
    parameter int W = 16
) (
    input  xd_mode_e             mode,
    input  logic [W-1:0]         opd_y,
    input  logic [W-1:0]         opd_d,
    input  logic [W-1:0]         opd_x,
    output logic [2*W-1:0]       dvd_mag,
    output logic [W-1:0]         dvs_mag,
    output logic                 q_neg,
    output logic                 r_neg,
    output logic                 narrow,
    output logic                 dvs_zero
);
    localparam int DW = 2 * W;

    logic           is_signed;
    logic           dvd_sign;
    logic           dvs_sign;
    logic [DW-1:0]  dvd_raw;

    always_comb begin
        is_signed = (mode == XD_SWIDE) || (mode == XD_SNARROW);
        narrow    = (mode == XD_SNARROW);

        if (narrow) begin
            dvd_raw = {{W{opd_d[W-1]}}, opd_d};
        end else begin
            dvd_raw = {opd_y, opd_d};
        end

        dvd_sign = is_signed && dvd_raw[DW-1];
        dvs_sign = is_signed && opd_x[W-1];

        dvd_mag  = dvd_sign ? (~dvd_raw + DW'(1)) : dvd_raw;
        dvs_mag  = dvs_sign ? (~opd_x + W'(1)) : opd_x;

        q_neg    = dvd_sign ^ dvs_sign;
        r_neg    = dvd_sign;
        dvs_zero = (opd_x == '0);
    end

endmodule

// File: rtl/xdiv_core.sv
// Restoring shift-subtract loop on magnitudes, one quotient bit per clock.
module xdiv_core #(
    parameter int W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             narrow_in,
    input  logic [2*W-1:0]   dvd_mag,
    input  logic [W-1:0]     dvs_mag,
    output logic [2*W-1:0]   quo_mag,
    output logic [W-1:0]     rem_mag,
    output logic             last_step
);
    localparam int DW    = 2 * W;
    localparam int CNT_W = $clog2(DW + 1);

    typedef struct packed {
        logic [W-1:0]     rem;
        logic [DW-1:0]    quo;
        logic [W-1:0]     dvs;
        logic [CNT_W-1:0] cnt;
        logic             active;
    } core_regs_t;

    core_regs_t q, d;

    logic [W:0] part;
    logic [W:0] diff;
    logic       fits;

    always_comb begin
        d    = q;
        part = {q.rem, q.quo[DW-1]};
        diff = part - {1'b0, q.dvs};
        fits = ~diff[W];

        if (load) begin
            d.rem    = '0;
            d.quo    = narrow_in ? {dvd_mag[W-1:0], {W{1'b0}}} : dvd_mag;
            d.dvs    = dvs_mag;
            d.cnt    = narrow_in ? CNT_W'(W) : CNT_W'(DW);
            d.active = 1'b1;
        end else if (q.active) begin
            d.rem = fits ? diff[W-1:0] : part[W-1:0];
            d.quo = {q.quo[DW-2:0], fits};
            d.cnt = q.cnt - CNT_W'(1);
            if (q.cnt == CNT_W'(1)) begin
                d.active = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign quo_mag   = q.quo;
    assign rem_mag   = q.rem;
    assign last_step = q.active && (q.cnt == CNT_W'(1));

endmodule

// File: rtl/xdiv_result_fix.sv
// Restores signs and derives the Z, N and V flags from the magnitudes.
module xdiv_result_fix
    import xdiv_pkg::*;
#(
    parameter int W = 16
) (
    input  xd_mode_e         mode,
    input  logic [2*W-1:0]   quo_mag,
    input  logic [W-1:0]     rem_mag,
    input  logic             q_neg,
    input  logic             r_neg,
    output logic [W-1:0]     q_out,
    output logic [W-1:0]     r_out,
    output logic             fz,
    output logic             fn,
    output logic             fv
);
    localparam int DW = 2 * W;
    localparam logic [DW-1:0] NEG_LIMIT = DW'(1) << (W - 1);
    localparam logic [DW-1:0] POS_LIMIT = NEG_LIMIT - DW'(1);

    logic [DW-1:0] q_signed;

    always_comb begin
        q_signed = q_neg ? (~quo_mag + DW'(1)) : quo_mag;
        q_out    = q_signed[W-1:0];
        r_out    = r_neg ? (~rem_mag + W'(1)) : rem_mag;
        fz       = (quo_mag == '0);
        fn       = q_out[W-1];

        if (mode == XD_UWIDE) begin
            fv = |quo_mag[DW-1:W];
        end else if (q_neg) begin
            fv = (quo_mag > NEG_LIMIT);
        end else begin
            fv = (quo_mag > POS_LIMIT);
        end
    end

endmodule

// File: rtl/xdiv_unit.sv
// Top level: sequencing, result registers and write strobes.
module xdiv_unit
    import xdiv_pkg::*;
#(
    parameter int W = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    mode,
    input  logic [W-1:0]  in_y,
    input  logic [W-1:0]  in_d,
    input  logic [W-1:0]  in_x,
    output logic          busy,
    output logic          done,
    output logic          wr_y,
    output logic          wr_x,
    output logic          wr_d,
    output logic [W-1:0]  res_y,
    output logic [W-1:0]  res_x,
    output logic [W-1:0]  res_d,
    output logic          flag_z,
    output logic          flag_n,
    output logic          flag_v,
    output logic          flag_c
);
    localparam int DW = 2 * W;

    typedef struct packed {
        xd_state_e    st;
        xd_mode_e     md;
        logic         qn;
        logic         rn;
        logic         zdiv;
        logic [W-1:0] ry;
        logic [W-1:0] rx;
        logic [W-1:0] rd;
        logic         fz;
        logic         fn;
        logic         fv;
        logic         fc;
        logic         dn;
        logic         wy;
        logic         wx;
        logic         wd;
    } top_regs_t;

    top_regs_t q, d;

    xd_mode_e      eff_mode;
    logic [DW-1:0] dvd_mag;
    logic [W-1:0]  dvs_mag;
    logic          p_qneg;
    logic          p_rneg;
    logic          p_narrow;
    logic          p_zero;
    logic          accept;
    logic          core_load;
    logic [DW-1:0] quo_mag;
    logic [W-1:0]  rem_mag;
    logic          core_last;
    logic [W-1:0]  fix_q;
    logic [W-1:0]  fix_r;
    logic          fix_z;
    logic          fix_n;
    logic          fix_v;

    // The reserved code folds onto the unsigned wide operation.
    assign eff_mode  = (mode == 2'd3) ? XD_UWIDE : xd_mode_e'(mode);
    assign accept    = start && (q.st == XS_IDLE);
    assign core_load = accept && !p_zero;

    xdiv_operand_prep #(.W(W)) u_prep (
        .mode     (eff_mode),
        .opd_y    (in_y),
        .opd_d    (in_d),
        .opd_x    (in_x),
        .dvd_mag  (dvd_mag),
        .dvs_mag  (dvs_mag),
        .q_neg    (p_qneg),
        .r_neg    (p_rneg),
        .narrow   (p_narrow),
        .dvs_zero (p_zero)
    );

    xdiv_core #(.W(W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (core_load),
        .narrow_in (p_narrow),
        .dvd_mag   (dvd_mag),
        .dvs_mag   (dvs_mag),
        .quo_mag   (quo_mag),
        .rem_mag   (rem_mag),
        .last_step (core_last)
    );

    xdiv_result_fix #(.W(W)) u_fix (
        .mode    (q.md),
        .quo_mag (quo_mag),
        .rem_mag (rem_mag),
        .q_neg   (q.qn),
        .r_neg   (q.rn),
        .q_out   (fix_q),
        .r_out   (fix_r),
        .fz      (fix_z),
        .fn      (fix_n),
        .fv      (fix_v)
    );

    always_comb begin
        d    = q;
        d.dn = 1'b0;
        d.wy = 1'b0;
        d.wx = 1'b0;
        d.wd = 1'b0;

        unique case (q.st)
            XS_IDLE: begin
                if (accept) begin
                    d.md   = eff_mode;
                    d.qn   = p_qneg;
                    d.rn   = p_rneg;
                    d.zdiv = p_zero;
                    d.st   = p_zero ? XS_FIN : XS_RUN;
                end
            end
            XS_RUN: begin
                if (core_last) begin
                    d.st = XS_FIN;
                end
            end
            XS_FIN: begin
                d.st = XS_IDLE;
                d.dn = 1'b1;
                if (q.zdiv) begin
                    d.fc = 1'b1;
                    d.fz = 1'b0;
                    d.fn = 1'b0;
                    d.fv = 1'b0;
                end else begin
                    d.fc = 1'b0;
                    d.fz = fix_z;
                    d.fn = fix_n;
                    d.fv = fix_v;
                    d.rd = fix_r;
                    d.wd = 1'b1;
                    if (q.md == XD_SNARROW) begin
                        d.rx = fix_q;
                        d.wx = 1'b1;
                    end else begin
                        d.ry = fix_q;
                        d.wy = 1'b1;
                    end
                end
            end
            default: begin
                d.st = XS_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy   = (q.st != XS_IDLE);
    assign done   = q.dn;
    assign wr_y   = q.wy;
    assign wr_x   = q.wx;
    assign wr_d   = q.wd;
    assign res_y  = q.ry;
    assign res_x  = q.rx;
    assign res_d  = q.rd;
    assign flag_z = q.fz;
    assign flag_n = q.fn;
    assign flag_v = q.fv;
    assign flag_c = q.fc;

endmodule

// File: rtl/xdiv_unit_chk.sv
module xdiv_unit_chk #(
    parameter int W = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          wr_y,
    input logic          wr_x,
    input logic          wr_d,
    input logic [W-1:0]  res_y,
    input logic [W-1:0]  res_x,
    input logic          flag_z,
    input logic          flag_n,
    input logic          flag_c
);

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r9_start_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy || done));

    a_r8_zero_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (done && flag_c) |-> (!wr_y && !wr_x && !wr_d));

    a_r2_write_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !flag_c) |-> (wr_d && $onehot({wr_x, wr_y})));

    a_r9_strobe_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_y || wr_x || wr_d) |-> done);

    a_r4_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (done && flag_z) |-> (!flag_n && (wr_x ? (res_x == '0) : (res_y == '0))));

endmodule

bind xdiv_unit xdiv_unit_chk #(.W(W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .wr_y   (wr_y),
    .wr_x   (wr_x),
    .wr_d   (wr_d),
    .res_y  (res_y),
    .res_x  (res_x),
    .flag_z (flag_z),
    .flag_n (flag_n),
    .flag_c (flag_c)
);

// File: tb/xdiv_unit_bench.sv
`timescale 1ns/1ps
module xdiv_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [15:0] in_y = '0;
    logic [15:0] in_d = '0;
    logic [15:0] in_x = '0;
    logic        busy, done, wr_y, wr_x, wr_d;
    logic [15:0] res_y, res_x, res_d;
    logic        flag_z, flag_n, flag_v, flag_c;

    int n_checks = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    xdiv_unit u_xdiv_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .in_y(in_y), .in_d(in_d), .in_x(in_x),
        .busy(busy), .done(done), .wr_y(wr_y), .wr_x(wr_x), .wr_d(wr_d),
        .res_y(res_y), .res_x(res_x), .res_d(res_d),
        .flag_z(flag_z), .flag_n(flag_n), .flag_v(flag_v), .flag_c(flag_c)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Run one operation; optionally fire a stray start mid-run.
    task automatic run_op(input string req, input logic [1:0] md,
                          input logic [15:0] y, input logic [15:0] dd,
                          input logic [15:0] x, input bit stray);
        logic [1:0]  em;
        longint      a, b, qq, rr;
        logic [15:0] eq, er;
        logic        ez, en, ev;
        logic [15:0] py, px, pd;
        int          lat, exp_lat;
        logic        seen_busy;

        em = (md == 2'd3) ? 2'd0 : md;
        if (em == 2'd0) begin
            a = longint'({y, dd});
            b = longint'(x);
        end else if (em == 2'd1) begin
            a = longint'($signed({y, dd}));
            b = longint'($signed(x));
        end else begin
            a = longint'($signed(dd));
            b = longint'($signed(x));
        end
        if (b != 0) begin
            qq = a / b;
            rr = a % b;
        end else begin
            qq = 0;
            rr = 0;
        end
        eq = qq[15:0];
        er = rr[15:0];
        ez = (qq == 0);
        en = eq[15];
        if (em == 2'd0) ev = (qq > 65535);
        else            ev = (qq > 32767) || (qq < -32768);
        exp_lat = (x == 0) ? 1 : ((em == 2'd2) ? 17 : 33);

        py = res_y; px = res_x; pd = res_d;

        @(negedge clk);
        mode = md; in_y = y; in_d = dd; in_x = x; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        seen_busy = 1'b0;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
            if (lat == 1) seen_busy = busy;
            if (stray && lat == 5) begin
                start = 1'b1; mode = 2'd2; in_d = 16'h0001; in_x = 16'h0001;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;

        chk("R9", "latency", 32'(lat), 32'(exp_lat));
        chk("R9", "busy after start", {31'b0, seen_busy}, {31'b0, (x != 0)});
        if (stray) chk("R10", "latency with stray start", 32'(lat), 32'(exp_lat));

        if (x == 0) begin
            chk("R8", "flags zcnv", {28'b0, flag_z, flag_c, flag_n, flag_v}, 32'h4);
            chk("R8", "strobes", {29'b0, wr_y, wr_x, wr_d}, 32'h0);
            chk("R8", "results held", {res_y, res_x ^ res_d}, {py, px ^ pd});
            chk("R8", "res_x held", {16'b0, res_x}, {16'b0, px});
        end else begin
            chk(req, "remainder", {16'b0, res_d}, {16'b0, er});
            if (em == 2'd2) begin
                chk(req, "quotient in X", {16'b0, res_x}, {16'b0, eq});
                chk("R7", "strobes", {29'b0, wr_y, wr_x, wr_d}, 32'h3);
                chk("R7", "Y untouched", {16'b0, res_y}, {16'b0, py});
            end else begin
                chk(req, "quotient in Y", {16'b0, res_y}, {16'b0, eq});
                chk("R2", "strobes", {29'b0, wr_y, wr_x, wr_d}, 32'h5);
            end
            chk("R4", "flag C", {31'b0, flag_c}, 32'h0);
            chk("R4", "flag Z", {31'b0, flag_z}, {31'b0, ez});
            chk("R4", "flag N", {31'b0, flag_n}, {31'b0, en});
            chk((em == 2'd0) ? "R3" : ((em == 2'd1) ? "R6" : "R7"),
                "flag V", {31'b0, flag_v}, {31'b0, ev});
        end
        @(negedge clk);
        chk("R9", "done is one cycle", {31'b0, done}, 32'h0);
    endtask

    task automatic t_reset();
        chk("R1", "busy/done", {30'b0, busy, done}, 32'h0);
        chk("R1", "strobes", {29'b0, wr_y, wr_x, wr_d}, 32'h0);
        chk("R1", "results", {res_y, res_x}, 32'h0);
        chk("R1", "res_d and flags", {12'b0, res_d, flag_z, flag_n, flag_v, flag_c}, 32'h0);
    endtask

    task automatic t_unsigned();
        run_op("R2", 2'd0, 16'h0001, 16'h2345, 16'h0100, 1'b0);
        run_op("R2", 2'd0, 16'h0000, 16'hFFFF, 16'h0007, 1'b0);
        run_op("R2", 2'd0, 16'h0000, 16'h0005, 16'h0009, 1'b0); // R4 zero quotient
    endtask

    task automatic t_unsigned_ovf();
        run_op("R3", 2'd0, 16'h0003, 16'hFFFF, 16'h0004, 1'b0); // just fits
        run_op("R3", 2'd0, 16'h0004, 16'h0000, 16'h0004, 1'b0); // 65536
        run_op("R3", 2'd0, 16'h1234, 16'h5678, 16'h0010, 1'b0);
    endtask

    task automatic t_signed_wide();
        run_op("R5", 2'd1, 16'hFFFF, 16'hFF00, 16'h0007, 1'b0);
        run_op("R5", 2'd1, 16'h0000, 16'h0064, 16'hFFF9, 1'b0);
        run_op("R5", 2'd1, 16'hFFFF, 16'hFF9C, 16'hFFF9, 1'b0);
    endtask

    task automatic t_signed_ovf();
        run_op("R6", 2'd1, 16'hFFFF, 16'h8000, 16'h0001, 1'b0); // -32768 fits
        run_op("R6", 2'd1, 16'h0000, 16'h8000, 16'h0001, 1'b0); // 32768
        run_op("R6", 2'd1, 16'h0001, 16'h0000, 16'h0001, 1'b0);
        run_op("R6", 2'd1, 16'h8000, 16'h0000, 16'hFFFF, 1'b0);
    endtask

    task automatic t_narrow();
        run_op("R7", 2'd2, 16'h5555, 16'hFF9C, 16'h0007, 1'b0);
        run_op("R7", 2'd2, 16'h0000, 16'h7FFF, 16'hFFFF, 1'b0);
        run_op("R7", 2'd2, 16'hAAAA, 16'h8000, 16'hFFFF, 1'b0);
    endtask

    task automatic t_zero();
        run_op("R8", 2'd0, 16'h1234, 16'h5678, 16'h0000, 1'b0);
        run_op("R8", 2'd1, 16'hFFFF, 16'h0001, 16'h0000, 1'b0);
        run_op("R8", 2'd2, 16'h0000, 16'h0042, 16'h0000, 1'b0);
    endtask

    task automatic t_busy_ignore();
        run_op("R10", 2'd0, 16'h0002, 16'h0000, 16'h0003, 1'b1);
    endtask

    task automatic t_reserved();
        run_op("R11", 2'd3, 16'hFFFF, 16'hFFFE, 16'h0002, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unsigned();
        t_unsigned_ovf();
        t_signed_wide();
        t_signed_ovf();
        t_narrow();
        t_zero();
        t_busy_ignore();
        t_reserved();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule